// File: doc/BRIEF.md
# Converter Startup and Fault Sequencer

This block supervises a synchronous step-down switching converter by counting switching-cycle ticks. After the converter is released from shutdown it ramps a 3-bit current-limit code from zero to full scale in quarter steps. It holds an active-low power-good reset output low for a fixed number of cycles. Output under-voltage protection stays disarmed until a separate cycle count has elapsed.

Digital comparator flags from the analog front end feed a latched fault policy. Output over-voltage, any input-supply under-voltage flag, or an armed output under-voltage latch the converter off with the low-side switch forced on. The latch clears only when the converter is shut down. Over-temperature acts like a shutdown and lasts until a separate release flag arrives. Leaving shutdown or thermal shutdown restarts every timer from zero.

All inputs are sampled on the rising clock edge. Every output reflects the inputs of the preceding edge, so an input change shows at the outputs one edge later.

Top module: `sfs_startup_seq`

## Requirements
- R1: While rst_ni or shdn_ni is low, the outputs are hiz_o=1, sw_en_o=0, ls_on_o=0, ilim_o=0 and por_no=0. At most one of hiz_o, sw_en_o and ls_on_o is ever high.
- R2: With n counted ticks since release, ilim_o equals min(n / (RAMP_CYCLES/4), 4). Code k means k quarters of full scale, with 0 meaning none and 4 meaning full. The first sample after release has n=0.
- R3: por_no stays low until RESET_CYCLES ticks have been counted since release. After that it goes high, unless a fault is latched.
- R4: Output under-voltage (uvp_i) is ignored while fewer than UV_ARM_CYCLES ticks have been counted. After that, uvp_i latches the fault state with sw_en_o=0, ls_on_o=1 and por_no=0.
- R5: A one-cycle ovp_i latches the fault state with sw_en_o=0, ls_on_o=1, hiz_o=0 and por_no=0. The state persists after ovp_i falls.
- R6: Any bit of sup_uv_i produces the same latched response as R5.
- R7: ot_trip_i puts the block into the R1 shutdown state. It stays there until ot_clear_i is seen while ot_trip_i is low, and a trip seen together with a clear wins. On release the timers restart from zero.
- R8: Releasing shdn_ni clears the fault latch and restarts all timers from zero.
- R9: Timers advance only on cycles with tick_i high. The ramp stops at code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| tick_i | input | 1 | one pulse per switching cycle |
| shdn_ni | input | 1 | active-low shutdown |
| ovp_i | input | 1 | output over-voltage flag |
| uvp_i | input | 1 | output under-voltage flag |
| sup_uv_i | input | N_SUP | input-supply under-voltage flags |
| ot_trip_i | input | 1 | over-temperature trip flag |
| ot_clear_i | input | 1 | over-temperature release flag |
| ilim_o | output | 3 | current-limit code, 0..4 quarters |
| sw_en_o | output | 1 | switching enable |
| ls_on_o | output | 1 | force low-side switch on |
| hiz_o | output | 1 | tri-state both gate drivers |
| por_no | output | 1 | active-low power-good reset |

## Verification
The hardest situation to reach is the boundary of under-voltage arming. A flag on the last disarmed tick must be ignored, while a flag some ticks later must latch, and the only visible difference is the switching enable one edge later. The stimulus counts ticks from a known release and places single-cycle uvp_i pulses on exact tick indices. Thermal recovery is the other difficult case. A trip and a clear in the same cycle must keep the block off, which the stimulus reaches by driving both flags together before a lone clear.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int unsigned ILIM_W     = 3;
  localparam int unsigned ILIM_STEPS = 4;
  typedef logic [ILIM_W-1:0] ilim_t;
endpackage

// File: rtl/sfs_sat_timer.sv
module sfs_sat_timer #(
  parameter int unsigned LIMIT = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (adv_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sfs_soft_ramp.sv
module sfs_soft_ramp
  import sfs_pkg::*;
#(
  parameter int unsigned RAMP_CYCLES = 512
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  adv_i,
  output ilim_t code_o
);
  localparam int unsigned STEP = RAMP_CYCLES / ILIM_STEPS;
  localparam int unsigned CW   = $clog2(RAMP_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          top;

  assign top = (cnt_q == CW'(RAMP_CYCLES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (adv_i && !top) cnt_q <= cnt_q + 1'b1;
  end

  // count never exceeds RAMP_CYCLES, so the quotient tops out at ILIM_STEPS
  assign code_o = ilim_t'(cnt_q / CW'(STEP));
endmodule

// File: rtl/sfs_fault_ctrl.sv
module sfs_fault_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shdn_ni,
  input  logic ot_trip_i,
  input  logic ot_clear_i,
  input  logic ovp_i,
  input  logic sup_uv_i,
  input  logic uvp_i,
  input  logic uv_armed_i,
  output logic run_d_o,
  output logic run_o,
  output logic fault_o
);
  logic hot_q, hot_d;
  logic run_q, fault_q, fault_d;

  // trip dominates release
  always_comb begin
    hot_d = hot_q;
    if (ot_trip_i)       hot_d = 1'b1;
    else if (ot_clear_i) hot_d = 1'b0;
  end

  assign run_d_o = shdn_ni && !hot_d;
  assign fault_d = run_d_o && (fault_q || ovp_i || sup_uv_i || (uv_armed_i && uvp_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_q   <= 1'b0;
      run_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      hot_q   <= hot_d;
      run_q   <= run_d_o;
      fault_q <= fault_d;
    end
  end

  assign run_o   = run_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/sfs_startup_seq.sv
module sfs_startup_seq
  import sfs_pkg::*;
#(
  parameter int unsigned RAMP_CYCLES   = 512,
  parameter int unsigned RESET_CYCLES  = 32768,
  parameter int unsigned UV_ARM_CYCLES = 5000,
  parameter int unsigned N_SUP         = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             shdn_ni,
  input  logic             ovp_i,
  input  logic             uvp_i,
  input  logic [N_SUP-1:0] sup_uv_i,
  input  logic             ot_trip_i,
  input  logic             ot_clear_i,
  output logic [2:0]       ilim_o,
  output logic             sw_en_o,
  output logic             ls_on_o,
  output logic             hiz_o,
  output logic             por_no
);
  localparam int unsigned N_TMR   = 2;
  localparam int unsigned TMR_POR = 0;
  localparam int unsigned TMR_UV  = 1;

  logic             run_d, run_q, fault_q;
  logic             clr, adv;
  logic [N_TMR-1:0] tmr_done;
  ilim_t            ramp_code;

  assign clr = !run_d;
  assign adv = run_q && tick_i;

  sfs_fault_ctrl u_fault (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shdn_ni    (shdn_ni),
    .ot_trip_i  (ot_trip_i),
    .ot_clear_i (ot_clear_i),
    .ovp_i      (ovp_i),
    .sup_uv_i   (|sup_uv_i),
    .uvp_i      (uvp_i),
    .uv_armed_i (tmr_done[TMR_UV]),
    .run_d_o    (run_d),
    .run_o      (run_q),
    .fault_o    (fault_q)
  );

  sfs_soft_ramp #(.RAMP_CYCLES(RAMP_CYCLES)) u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (adv),
    .code_o (ramp_code)
  );

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    sfs_sat_timer #(
      .LIMIT((g == TMR_POR) ? RESET_CYCLES : UV_ARM_CYCLES)
    ) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .adv_i  (adv),
      .done_o (tmr_done[g])
    );
  end

  assign hiz_o   = !run_q;
  assign sw_en_o = run_q && !fault_q;
  assign ls_on_o = run_q && fault_q;
  assign por_no  = run_q && tmr_done[TMR_POR] && !fault_q;
  assign ilim_o  = run_q ? ramp_code : '0;
endmodule

// File: rtl/sfs_seq_checker.sv
module sfs_seq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       shdn_ni,
  input logic       ovp_i,
  input logic       ot_trip_i,
  input logic [2:0] ilim_o,
  input logic       sw_en_o,
  input logic       ls_on_o,
  input logic       hiz_o,
  input logic       por_no
);
  a_r1_one_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sw_en_o, ls_on_o, hiz_o}));

  a_r1_shdn_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shdn_ni |=> hiz_o && !sw_en_o && !ls_on_o && ilim_o == 3'd0);

  a_r2_ilim_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilim_o <= 3'd4);

  a_r2_ilim_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hiz_o && shdn_ni && !ot_trip_i) |=>
      (ilim_o == $past(ilim_o) || ilim_o == $past(ilim_o) + 3'd1));

  a_r3_por_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiz_o |-> !por_no);

  a_r5_ov_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovp_i |=> !sw_en_o && !por_no);

  a_r5_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ls_on_o && shdn_ni && !ot_trip_i) |=> ls_on_o);

  a_r7_ot_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_trip_i |=> hiz_o);

  a_r9_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !hiz_o && shdn_ni && !ot_trip_i) |=> ilim_o == $past(ilim_o));
endmodule

bind sfs_startup_seq sfs_seq_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .shdn_ni   (shdn_ni),
  .ovp_i     (ovp_i),
  .ot_trip_i (ot_trip_i),
  .ilim_o    (ilim_o),
  .sw_en_o   (sw_en_o),
  .ls_on_o   (ls_on_o),
  .hiz_o     (hiz_o),
  .por_no    (por_no)
);

// File: tb/tb_sfs_startup_seq.sv
`timescale 1ns/1ps
module tb_sfs_startup_seq;
  localparam int unsigned RAMP = 16;  // step 4
  localparam int unsigned RST  = 40;
  localparam int unsigned UVA  = 24;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0, tick_i = 1'b1, shdn_ni = 1'b1;
  logic       ovp_i = 1'b0, uvp_i = 1'b0, ot_trip_i = 1'b0, ot_clear_i = 1'b0;
  logic [1:0] sup_uv_i = 2'b00;
  logic [2:0] ilim_o;
  logic       sw_en_o, ls_on_o, hiz_o, por_no;

  int n_tests = 0, n_fail = 0;
  bit fin = 1'b0;

  always #10 clk = ~clk;

  sfs_startup_seq #(.RAMP_CYCLES(RAMP), .RESET_CYCLES(RST), .UV_ARM_CYCLES(UVA), .N_SUP(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .shdn_ni(shdn_ni), .ovp_i(ovp_i),
    .uvp_i(uvp_i), .sup_uv_i(sup_uv_i), .ot_trip_i(ot_trip_i), .ot_clear_i(ot_clear_i),
    .ilim_o(ilim_o), .sw_en_o(sw_en_o), .ls_on_o(ls_on_o), .hiz_o(hiz_o), .por_no(por_no)
  );

  // {ticks to advance, expected ilim, expected por_no}, walked from tick 0
  localparam int VEC [10][3] = '{
    '{0, 0, 0}, '{3, 0, 0}, '{1, 1, 0}, '{4, 2, 0}, '{4, 3, 0},
    '{3, 3, 0}, '{1, 4, 0}, '{23, 4, 0}, '{1, 4, 1}, '{20, 4, 1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shut();
    @(negedge clk); shdn_ni = 1'b0;
    @(negedge clk);
  endtask

  task automatic release_run();
    @(negedge clk); shdn_ni = 1'b1;
    @(negedge clk);  // tick count 0
  endtask

  task automatic chk_off(input string req);
    chk({req, " hiz"}, int'(hiz_o), 1);
    chk({req, " sw_en"}, int'(sw_en_o), 0);
    chk({req, " ls_on"}, int'(ls_on_o), 0);
    chk({req, " ilim"}, int'(ilim_o), 0);
    chk({req, " por"}, int'(por_no), 0);
  endtask

  task automatic chk_latched(input string req);
    chk({req, " sw_en"}, int'(sw_en_o), 0);
    chk({req, " ls_on"}, int'(ls_on_o), 1);
    chk({req, " hiz"}, int'(hiz_o), 0);
    chk({req, " por"}, int'(por_no), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    wait_n(3);
    chk_off("R1 reset");
    shdn_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    wait_n(2);
    chk_off("R1 shutdown held");

    // R2/R3 table walk
    release_run();
    foreach (VEC[i]) begin
      wait_n(VEC[i][0]);
      chk("R2 ilim ramp", int'(ilim_o), VEC[i][1]);
      chk("R3 por timer", int'(por_no), VEC[i][2]);
      chk("R2 sw_en running", int'(sw_en_o), 1);
    end

    // R1 shutdown mid-run, R8 restart from zero
    shut();
    chk_off("R1 shutdown");
    release_run();
    chk("R8 restart ilim", int'(ilim_o), 0);
    chk("R8 restart por", int'(por_no), 0);

    // R9 tick gating
    wait_n(3);
    tick_i = 1'b0;
    wait_n(10);
    chk("R9 hold without ticks", int'(ilim_o), 0);
    tick_i = 1'b1;
    wait_n(1);
    chk("R9 resume", int'(ilim_o), 1);

    // R4 arming boundary
    shut(); release_run();
    wait_n(23);
    uvp_i = 1'b1;
    @(negedge clk); uvp_i = 1'b0;
    chk("R4 uv ignored before arm", int'(sw_en_o), 1);
    wait_n(20);
    chk("R4 por before uv", int'(por_no), 1);
    uvp_i = 1'b1;
    @(negedge clk); uvp_i = 1'b0;
    chk_latched("R4 armed uv");
    wait_n(5);
    chk("R4 uv latched", int'(ls_on_o), 1);

    // R8 latch cleared by shutdown, R5 over-voltage
    shut(); release_run();
    chk("R8 latch cleared sw_en", int'(sw_en_o), 1);
    chk("R8 latch cleared ls_on", int'(ls_on_o), 0);
    wait_n(5);
    ovp_i = 1'b1;
    @(negedge clk); ovp_i = 1'b0;
    chk_latched("R5 ov");
    wait_n(50);
    chk_latched("R5 ov held past por time");

    // R6 each supply flag
    for (int b = 0; b < 2; b++) begin
      shut(); release_run();
      chk("R6 pre sw_en", int'(sw_en_o), 1);
      sup_uv_i = 2'(1 << b);
      @(negedge clk); sup_uv_i = 2'b00;
      chk_latched($sformatf("R6 supply bit %0d", b));
    end

    // R7 over-temperature
    shut(); release_run();
    wait_n(6);
    ot_trip_i = 1'b1;
    @(negedge clk); ot_trip_i = 1'b0;
    chk_off("R7 trip");
    wait_n(5);
    chk("R7 stays off", int'(hiz_o), 1);
    ot_trip_i = 1'b1; ot_clear_i = 1'b1;
    @(negedge clk); ot_trip_i = 1'b0; ot_clear_i = 1'b0;
    chk("R7 trip beats clear", int'(hiz_o), 1);
    ot_clear_i = 1'b1;
    @(negedge clk); ot_clear_i = 1'b0;
    chk("R7 released hiz", int'(hiz_o), 0);
    chk("R7 released ilim", int'(ilim_o), 0);
    wait_n(4);
    chk("R7 timers restarted", int'(ilim_o), 1);

    fin = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule